// File: doc/BRIEF.md
# Burst Address Generator

This block produces the address for each beat of a short memory burst. A new start address is captured whenever either of two active-low address strobes is sampled low. After that, each clock edge on which the advance input is low and both strobes are high steps the burst to its next beat. Any other edge without a load holds the current address, which suspends the burst. Only the low offset field of the address moves during a burst. The upper field is passed through unchanged from the captured start address.

Two beat orderings are supported. A static order-select input picks between them and is sampled only on load edges. With the select high, each beat offset is the start offset XORed with a running beat count. With the select low, each beat offset is the start offset plus the count, wrapping inside the offset field. The offset field is `OFS_W` bits wide, so a burst has 2**`OFS_W` beats. The default is two bits, which gives four beats. The generated address is held in registers and is valid from the clock edge that loads it or advances it.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the address output becomes all zeros, the beat count becomes zero and the ordering becomes XOR. An advance right after reset therefore gives offset 1.
- R2: On an edge where `strb_a_n` or `strb_b_n` is low, the whole `start_addr` is captured and appears on `burst_addr` after that edge. `adv_n` is ignored on that edge.
- R3: When `order_sel` was high at the last load, the offset field of `burst_addr` equals the start offset XOR the beat count. For four beats this gives start^00, start^01, start^10 and start^11.
- R4: When `order_sel` was low at the last load, the offset field equals (start offset + beat count) modulo 2**`OFS_W`.
- R5: The beat count increments only on an edge where `adv_n` is low and both strobes are high. An edge with both strobes high and `adv_n` high leaves `burst_addr` unchanged.
- R6: A change of `order_sel` between loads has no effect on the ordering of the burst in progress.
- R7: After 2**`OFS_W` advances the count wraps to zero, so `burst_addr` returns to the loaded start address.
- R8: Between loads, bits above the offset field never change. In linear order there is no carry out of the offset field.
- R9: A load during a burst restarts the beat count at zero, whatever its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| strb_a_n | input | 1 | First address strobe, active low; loads a start address |
| strb_b_n | input | 1 | Second address strobe, active low; loads a start address |
| adv_n | input | 1 | Advance request, active low |
| order_sel | input | 1 | Ordering select: 1 = XOR order, 0 = linear order; sampled at load |
| start_addr | input | ADDR_W | Burst start address |
| burst_addr | output | ADDR_W | Current beat address |

## Verification
The main instance of the bench is built with `ADDR_W` = 10 and `OFS_W` = 2. At this size, full four-beat sequences in both orderings can be checked against hand-computed addresses. This includes offsets that wrap past the field top, where a carry would show up in the upper bits. A second instance is built with `ADDR_W` = 6 and `OFS_W` = 3. It runs an eight-beat XOR burst through its wrap and a linear burst across the offset boundary, which shows that the orderings follow the parameter and are not fixed at four beats.

// File: rtl/burst_pkg.sv
// Package: shared types for the burst address generator.
// Assumes: nothing beyond IEEE 1800-2017.
package burst_pkg;

    // Beat ordering, the value of the order-select pin when it is captured.
    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

endpackage

// File: rtl/burst_seq_ctrl.sv
// Module: burst_seq_ctrl
// Decodes the strobe and advance inputs into a load command and a step
// command. Load has priority, so advance is ignored on a load edge.
// Assumes: all inputs are synchronous and active low.
module burst_seq_ctrl (
    input  logic strb_a_n,
    input  logic strb_b_n,
    input  logic adv_n,
    output logic load,
    output logic step
);

    // Command decode: either strobe loads; otherwise advance steps.
    always_comb begin
        load = (!strb_a_n) || (!strb_b_n);
        step = (!load) && (!adv_n);
    end

endmodule

// File: rtl/burst_offset_cnt.sv
// Module: burst_offset_cnt
// Running beat count of OFS_W bits. It clears on load, increments on step
// and wraps naturally at 2**OFS_W.
// Assumes: load and step are never both high (guaranteed by burst_seq_ctrl).
module burst_offset_cnt #(
    parameter int OFS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    output logic [OFS_W-1:0] cnt
);

    localparam logic [OFS_W-1:0] CNT_ONE = OFS_W'(1);

    // Count register: clear on reset or load, add one on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + CNT_ONE;
        end
    end

endmodule

// File: rtl/burst_order_map.sv
// Module: burst_order_map
// Combines the captured start offset with the beat count according to the
// captured ordering: XOR for interleaved order, modulo add for linear order.
// Assumes: purely combinational; the adder result is truncated to OFS_W.
module burst_order_map
    import burst_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic [OFS_W-1:0] base,
    input  logic [OFS_W-1:0] cnt,
    input  order_e           order,
    output logic [OFS_W-1:0] ofs
);

    logic [OFS_W-1:0] ofs_xor;
    logic [OFS_W-1:0] ofs_lin;

    // Per-bit XOR variant, built bit by bit.
    for (genvar b = 0; b < OFS_W; b++) begin : g_xor_bit
        assign ofs_xor[b] = base[b] ^ cnt[b];
    end

    // Modulo add variant: the carry out of the field is dropped.
    always_comb begin
        ofs_lin = base + cnt;
    end

    // Ordering select.
    always_comb begin
        ofs = (order == ORD_XOR) ? ofs_xor : ofs_lin;
    end

endmodule

// File: rtl/burst_addr_gen.sv
// Module: burst_addr_gen (top)
// Burst address generator. It captures a start address on either strobe
// and steps the low OFS_W bits through an XOR or linear order on advance.
// Upper bits are held from the captured address.
// Assumes: order_sel is static during a burst; it is sampled only at load.
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strb_a_n,
    input  logic              strb_b_n,
    input  logic              adv_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] burst_addr
);

    localparam int UP_W = ADDR_W - OFS_W;

    logic              load;
    logic              step;
    logic [OFS_W-1:0]  cnt;
    logic [OFS_W-1:0]  base_q;
    logic [UP_W-1:0]   upper_q;
    order_e            order_q;
    logic [OFS_W-1:0]  ofs;

    burst_seq_ctrl u_ctrl (
        .strb_a_n (strb_a_n),
        .strb_b_n (strb_b_n),
        .adv_n    (adv_n),
        .load     (load),
        .step     (step)
    );

    burst_offset_cnt #(.OFS_W(OFS_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .cnt   (cnt)
    );

    // Start address and ordering capture on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            upper_q <= '0;
            order_q <= ORD_XOR;
        end else if (load) begin
            base_q  <= start_addr[OFS_W-1:0];
            upper_q <= start_addr[ADDR_W-1:OFS_W];
            order_q <= order_e'(order_sel);
        end
    end

    burst_order_map #(.OFS_W(OFS_W)) u_map (
        .base  (base_q),
        .cnt   (cnt),
        .order (order_q),
        .ofs   (ofs)
    );

    // Output assembly: held upper field plus the mapped offset.
    always_comb begin
        burst_addr = {upper_q, ofs};
    end

endmodule

// File: rtl/burst_addr_gen_chk.sv
// Module: burst_addr_gen_chk
// Assertion checker bound to burst_addr_gen. It watches only the ports and
// keeps its own shadow of the last loaded address and an advance tally.
// Assumes: connected through the bind below.
module burst_addr_gen_chk #(
    parameter int ADDR_W = 17,
    parameter int OFS_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strb_a_n,
    input logic              strb_b_n,
    input logic              adv_n,
    input logic [ADDR_W-1:0] start_addr,
    input logic [ADDR_W-1:0] burst_addr
);

    logic              seen_q;
    logic [OFS_W-1:0]  adv_tally_q;
    logic [ADDR_W-1:0] loaded_q;
    logic              ld;

    always_comb ld = (!strb_a_n) || (!strb_b_n);

    // Shadow of the last load and the number of advances since, mod 2**OFS_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q      <= 1'b0;
            adv_tally_q <= '0;
            loaded_q    <= '0;
        end else if (ld) begin
            seen_q      <= 1'b1;
            adv_tally_q <= '0;
            loaded_q    <= start_addr;
        end else if (!adv_n) begin
            adv_tally_q <= adv_tally_q + OFS_W'(1);
        end
    end

    a_r2_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (burst_addr == $past(start_addr)));

    a_r5_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && adv_n) |=> $stable(burst_addr));

    a_r5_advance_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !adv_n) |=> (burst_addr != $past(burst_addr)));

    a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld) |=> (burst_addr[ADDR_W-1:OFS_W] == $past(burst_addr[ADDR_W-1:OFS_W])));

    a_r7_wrap_home: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && adv_tally_q == '0) |-> (burst_addr == loaded_q));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb_a_n   (strb_a_n),
    .strb_b_n   (strb_b_n),
    .adv_n      (adv_n),
    .start_addr (start_addr),
    .burst_addr (burst_addr)
);

// File: tb/burst_addr_gen_tb_top.sv
// Bench for burst_addr_gen: a vector table walked by one loop, then directed
// tests for reset, an eight-beat variant and the watchdog.
module burst_addr_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;

    typedef struct packed {
        logic       a_n;
        logic       b_n;
        logic       adv_n;
        logic       sel;
        logic [9:0] addr;
        logic [9:0] expv;
    } vec_t;

    // Columns: strb_a_n, strb_b_n, adv_n, order_sel, start_addr, expected.
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 1'b0, 1'b1, 10'h2A5, 10'h2A5}, // R2 load, adv ignored
        '{1'b1, 1'b1, 1'b0, 1'b1, 10'h000, 10'h2A4}, // R3 01^01
        '{1'b1, 1'b1, 1'b0, 1'b1, 10'h000, 10'h2A7}, // R3 01^10
        '{1'b1, 1'b1, 1'b1, 1'b1, 10'h000, 10'h2A7}, // R5 suspend
        '{1'b1, 1'b1, 1'b0, 1'b0, 10'h000, 10'h2A6}, // R6 sel flip ignored
        '{1'b1, 1'b1, 1'b0, 1'b0, 10'h000, 10'h2A5}, // R7 wrap home
        '{1'b1, 1'b0, 1'b1, 1'b0, 10'h1FE, 10'h1FE}, // R2 load by b, linear
        '{1'b1, 1'b1, 1'b0, 1'b1, 10'h000, 10'h1FF}, // R4 10+1
        '{1'b1, 1'b1, 1'b0, 1'b1, 10'h000, 10'h1FC}, // R8 no carry
        '{1'b1, 1'b1, 1'b0, 1'b1, 10'h000, 10'h1FD}, // R4 10+3
        '{1'b1, 1'b1, 1'b0, 1'b1, 10'h000, 10'h1FE}, // R7 wrap home
        '{1'b1, 1'b1, 1'b0, 1'b1, 10'h000, 10'h1FF}, // R4 again
        '{1'b0, 1'b0, 1'b0, 1'b0, 10'h003, 10'h003}, // R9 reload mid-burst
        '{1'b1, 1'b1, 1'b0, 1'b0, 10'h000, 10'h000}, // R9 count restarted
        '{1'b1, 1'b1, 1'b0, 1'b0, 10'h000, 10'h001}  // R4 3+2
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       strb_a_n, strb_b_n, adv_n, order_sel;
    logic [9:0] start_addr, burst_addr;
    logic       s_a_n, s_b_n, s_adv_n, s_sel;
    logic [5:0] s_start, s_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen #(.ADDR_W(10), .OFS_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .strb_a_n(strb_a_n), .strb_b_n(strb_b_n),
        .adv_n(adv_n), .order_sel(order_sel), .start_addr(start_addr),
        .burst_addr(burst_addr)
    );

    burst_addr_gen #(.ADDR_W(6), .OFS_W(3)) dut8_i (
        .clk(clk), .rst_n(rst_n), .strb_a_n(s_a_n), .strb_b_n(s_b_n),
        .adv_n(s_adv_n), .order_sel(s_sel), .start_addr(s_start),
        .burst_addr(s_addr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0;
        strb_a_n = 1'b1; strb_b_n = 1'b1; adv_n = 1'b1; order_sel = 1'b1;
        start_addr = '0;
        s_a_n = 1'b1; s_b_n = 1'b1; s_adv_n = 1'b1; s_sel = 1'b1; s_start = '0;
        repeat (3) @(negedge clk);
        check("R1 reset value", 32'(burst_addr), 32'h0);
        rst_n = 1'b1;

        // Vector table walk: drive at negedge, check after the next rising edge.
        for (int i = 0; i < NVEC; i++) begin
            strb_a_n   = VECS[i].a_n;
            strb_b_n   = VECS[i].b_n;
            adv_n      = VECS[i].adv_n;
            order_sel  = VECS[i].sel;
            start_addr = VECS[i].addr;
            @(negedge clk);
            check($sformatf("R2-table vec %0d", i), 32'(burst_addr), 32'(VECS[i].expv));
        end

        // Reset in mid-burst, then advance: XOR order from base 0 gives 1 (R1).
        strb_a_n = 1'b0; start_addr = 10'h155; adv_n = 1'b1;
        @(negedge clk);
        strb_a_n = 1'b1; adv_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-burst reset", 32'(burst_addr), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 advance after reset", 32'(burst_addr), 32'h1);
        adv_n = 1'b1;

        // Eight-beat instance, XOR order: offset 101 ^ k, upper 010 (R3, R7).
        s_a_n = 1'b0; s_sel = 1'b1; s_start = 6'h15;
        @(negedge clk);
        check("R2 eight-beat load", 32'(s_addr), 32'h15);
        s_a_n = 1'b1; s_adv_n = 1'b0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            check($sformatf("R3 eight-beat xor k=%0d", k), 32'(s_addr),
                  32'({3'b010, 3'b101 ^ 3'(k)}));
        end

        // Eight-beat instance, linear order across the field top (R4, R8).
        s_b_n = 1'b0; s_sel = 1'b0; s_start = 6'h2E; s_adv_n = 1'b1;
        @(negedge clk);
        s_b_n = 1'b1; s_adv_n = 1'b0;
        @(negedge clk);
        check("R4 eight-beat linear +1", 32'(s_addr), 32'h2F);
        @(negedge clk);
        check("R8 eight-beat no carry", 32'(s_addr), 32'h28);
        s_adv_n = 1'b1;
        @(negedge clk);
        check("R5 eight-beat suspend", 32'(s_addr), 32'h28);

        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule